// File: doc/BRIEF.md
# Postfix Stack Engine

This block executes a stream of postfix-ordered instructions on a small internal operand stack. Each instruction is offered with a valid/ready handshake. Two instructions move data between the stack and a word-addressed synchronous data memory: a load places a memory word on top of the stack, and a store writes the top of the stack to memory. Two arithmetic instructions, add and multiply, take no operands. Each one replaces the two uppermost stack entries with a single result. A stop instruction freezes the unit until reset.

The memory port is single-ported and has one cycle of read latency. A load therefore holds `instr_ready` low for one wait cycle while the read data comes back. Stack misuse is reported and not trapped. A load onto a full stack raises a sticky overflow flag. A store from an empty stack, or an arithmetic step with fewer than two entries, raises a sticky underflow flag. In both cases the stack and memory keep their contents.

Top module: `postfix_engine`

## Requirements
- R1: An instruction word is accepted on a rising edge where `instr_valid` and `instr_ready` are both high. Bits [15:12] hold the opcode and bits [11:0] hold the address. The opcodes are 4'h1 load, 4'h2 store, 4'h3 add, 4'h4 multiply and 4'hF stop. `mem_rd` and `mem_wr` are only ever high in an accepting cycle, and never both at once.
- R2: A load drives `mem_rd` with `mem_addr` equal to the address field during its accepting cycle. The word returned on `mem_rdata` in the following cycle goes on top of the stack. `instr_ready` is low for exactly that one following cycle.
- R3: A store drives `mem_wr` during its accepting cycle, with `mem_addr` equal to the address field and `mem_wdata` equal to the top entry. It then removes that entry.
- R4: Add replaces the two uppermost entries with their sum modulo 2^16.
- R5: Multiply replaces the two uppermost entries with the low 16 bits of their product.
- R6: The stack holds 8 entries in last-in first-out order. Stores return entries in the reverse of their load order.
- R7: A load onto a full stack issues no memory read and leaves the stack unchanged. It sets `overflow`, which stays high until reset.
- R8: A store on an empty stack, or an add or multiply with fewer than two entries, issues no memory write and leaves the stack unchanged. It sets `underflow`, which stays high until reset.
- R9: After a stop instruction is accepted, `halted` is high and `instr_ready` is low until reset. Offered instructions then cause no memory access.
- R10: An instruction with any other opcode is accepted and has no effect on the stack, the memory or the flags.
- R11: The program load X, load Y, multiply, load W, load U, multiply, add, store Z writes X*Y + W*U (modulo 2^16) to address Z.
- R12: After reset, `instr_ready` is high, the stack is empty, and `overflow`, `underflow`, `halted`, `mem_rd` and `mem_wr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word offered |
| instr_ready | output | 1 | Unit can accept an instruction this cycle |
| instr_word | input | 16 | Opcode in [15:12], address in [11:0] |
| mem_rd | output | 1 | Data memory read strobe |
| mem_wr | output | 1 | Data memory write strobe |
| mem_addr | output | 12 | Data memory word address |
| mem_wdata | output | 16 | Data memory write word |
| mem_rdata | input | 16 | Data memory read word, one cycle after `mem_rd` |
| overflow | output | 1 | Sticky: load attempted on full stack |
| underflow | output | 1 | Sticky: too few entries for store or arithmetic |
| halted | output | 1 | Stop instruction accepted |

## Verification
The hardest condition to reach from the ports is a full stack that must then be shown to be intact. The bench loads nine distinct words so that the ninth load meets a full stack. It then stores all eight remaining entries to separate addresses, and the scoreboard checks that they leave in exact reverse order. A lost or overwritten slot shows up there. The underflow case is handled the same way: a rejected add is followed by a store that must still return the lone entry. The wait cycle after each load is observed directly on `instr_ready`.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
   localparam logic [3:0] OPC_LOAD  = 4'h1;
   localparam logic [3:0] OPC_STORE = 4'h2;
   localparam logic [3:0] OPC_ADD   = 4'h3;
   localparam logic [3:0] OPC_MUL   = 4'h4;
   localparam logic [3:0] OPC_STOP  = 4'hF;

   typedef enum logic [1:0] {
      ST_RUN  = 2'd0,
      ST_LOAD = 2'd1,
      ST_STOP = 2'd2
   } eng_state_e;
endpackage

// File: rtl/pfx_decode.sv
module pfx_decode #(
   parameter int AW  = 12,
   parameter int OPW = 4,
   localparam int IW = OPW + AW
) (
   input  logic [IW-1:0] word,
   output logic          is_load,
   output logic          is_store,
   output logic          is_add,
   output logic          is_mul,
   output logic          is_stop,
   output logic [AW-1:0] addr
);
   import pfx_pkg::*;

   generate
      if (OPW != 4) begin : g_bad_opw
         $error("pfx_decode: opcode field must be 4 bits wide");
      end
   endgenerate

   logic [OPW-1:0] opc;
   assign opc  = word[IW-1 -: OPW];
   assign addr = word[AW-1:0];

   always_comb begin
      is_load  = (opc == OPC_LOAD);
      is_store = (opc == OPC_STORE);
      is_add   = (opc == OPC_ADD);
      is_mul   = (opc == OPC_MUL);
      is_stop  = (opc == OPC_STOP);
   end
endmodule

// File: rtl/pfx_alu.sv
module pfx_alu #(
   parameter int DW = 16
) (
   input  logic [DW-1:0] lhs,
   input  logic [DW-1:0] rhs,
   input  logic          mul_sel,
   output logic [DW-1:0] res
);
   generate
      if (DW < 1) begin : g_bad_dw
         $error("pfx_alu: data width must be positive");
      end
   endgenerate

   logic [DW-1:0] sum_w;
   logic [DW-1:0] prod_w;

   always_comb begin
      sum_w  = lhs + rhs;
      prod_w = lhs * rhs;
      res    = mul_sel ? prod_w : sum_w;
   end
endmodule

// File: rtl/pfx_stack.sv
module pfx_stack #(
   parameter int DW    = 16,
   parameter int DEPTH = 8,
   localparam int CW   = $clog2(DEPTH + 1),
   localparam int IXW  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_en,
   input  logic [DW-1:0] push_data,
   input  logic          pop_en,
   input  logic          fold_en,
   input  logic [DW-1:0] fold_data,
   output logic [DW-1:0] top,
   output logic [DW-1:0] second,
   output logic          full,
   output logic          empty,
   output logic          few
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("pfx_stack: depth must hold at least two entries");
      end
   endgenerate

   logic [DEPTH-1:0][DW-1:0] slot_q;
   logic [CW-1:0]            cnt_q;
   logic [IXW-1:0]           top_ix;
   logic [IXW-1:0]           sec_ix;

   assign top_ix = IXW'(cnt_q - CW'(1));
   assign sec_ix = IXW'(cnt_q - CW'(2));
   assign top    = slot_q[top_ix];
   assign second = slot_q[sec_ix];
   assign full   = (cnt_q == CW'(DEPTH));
   assign empty  = (cnt_q == '0);
   assign few    = (cnt_q < CW'(2));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_q <= '0;
         cnt_q  <= '0;
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (push_en && cnt_q == CW'(i))
               slot_q[i] <= push_data;
            else if (fold_en && cnt_q == CW'(i + 2))
               slot_q[i] <= fold_data;
         end
         if (push_en)
            cnt_q <= cnt_q + CW'(1);
         else if (pop_en || fold_en)
            cnt_q <= cnt_q - CW'(1);
      end
   end
endmodule

// File: rtl/postfix_engine.sv
module postfix_engine #(
   parameter int DW    = 16,
   parameter int AW    = 12,
   parameter int OPW   = 4,
   parameter int DEPTH = 8,
   localparam int IW   = OPW + AW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          instr_valid,
   output logic          instr_ready,
   input  logic [IW-1:0] instr_word,
   output logic          mem_rd,
   output logic          mem_wr,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   output logic          overflow,
   output logic          underflow,
   output logic          halted
);
   import pfx_pkg::*;

   eng_state_e    state_q, state_d;
   logic          fire;
   logic          d_load, d_store, d_add, d_mul, d_stop;
   logic [AW-1:0] d_addr;
   logic          st_full, st_empty, st_few;
   logic [DW-1:0] st_top, st_second, alu_res;
   logic          load_ok, load_bad, store_ok, store_bad, arith_ok, arith_bad;
   logic          ovf_q, unf_q;

   pfx_decode #(.AW(AW), .OPW(OPW)) u_decode (
      .word     (instr_word),
      .is_load  (d_load),
      .is_store (d_store),
      .is_add   (d_add),
      .is_mul   (d_mul),
      .is_stop  (d_stop),
      .addr     (d_addr)
   );

   assign instr_ready = (state_q == ST_RUN);
   assign fire        = instr_valid && instr_ready;

   always_comb begin
      load_ok   = fire && d_load  && !st_full;
      load_bad  = fire && d_load  &&  st_full;
      store_ok  = fire && d_store && !st_empty;
      store_bad = fire && d_store &&  st_empty;
      arith_ok  = fire && (d_add || d_mul) && !st_few;
      arith_bad = fire && (d_add || d_mul) &&  st_few;
   end

   pfx_alu #(.DW(DW)) u_alu (
      .lhs     (st_second),
      .rhs     (st_top),
      .mul_sel (d_mul),
      .res     (alu_res)
   );

   pfx_stack #(.DW(DW), .DEPTH(DEPTH)) u_stack (
      .clk       (clk),
      .rst_n     (rst_n),
      .push_en   (state_q == ST_LOAD),
      .push_data (mem_rdata),
      .pop_en    (store_ok),
      .fold_en   (arith_ok),
      .fold_data (alu_res),
      .top       (st_top),
      .second    (st_second),
      .full      (st_full),
      .empty     (st_empty),
      .few       (st_few)
   );

   assign mem_rd    = load_ok;
   assign mem_wr    = store_ok;
   assign mem_addr  = d_addr;
   assign mem_wdata = st_top;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_RUN: begin
            if (load_ok)
               state_d = ST_LOAD;
            else if (fire && d_stop)
               state_d = ST_STOP;
         end
         ST_LOAD: state_d = ST_RUN;
         default: state_d = ST_STOP;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_RUN;
         ovf_q   <= 1'b0;
         unf_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         ovf_q   <= ovf_q | load_bad;
         unf_q   <= unf_q | store_bad | arith_bad;
      end
   end

   assign overflow  = ovf_q;
   assign underflow = unf_q;
   assign halted    = (state_q == ST_STOP);
endmodule

// File: rtl/pfx_checker.sv
module pfx_checker #(
   parameter int DW  = 16,
   parameter int AW  = 12,
   parameter int OPW = 4,
   localparam int IW = OPW + AW
) (
   input logic          clk,
   input logic          rst_n,
   input logic          instr_valid,
   input logic          instr_ready,
   input logic [IW-1:0] instr_word,
   input logic          mem_rd,
   input logic          mem_wr,
   input logic [AW-1:0] mem_addr,
   input logic [DW-1:0] mem_wdata,
   input logic [DW-1:0] mem_rdata,
   input logic          overflow,
   input logic          underflow,
   input logic          halted
);
   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr)); // R1
   AST_STROBE_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_wr) |-> (instr_valid && instr_ready)); // R1
   AST_LOAD_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> !instr_ready); // R2
   AST_LOAD_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> ##1 (instr_ready || halted)); // R2
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow); // R7
   AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      underflow |=> underflow); // R8
   AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted); // R9
   AST_HALT_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> !instr_ready); // R9
endmodule

bind postfix_engine pfx_checker #(.DW(DW), .AW(AW), .OPW(OPW)) u_pfx_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .instr_valid (instr_valid),
   .instr_ready (instr_ready),
   .instr_word  (instr_word),
   .mem_rd      (mem_rd),
   .mem_wr      (mem_wr),
   .mem_addr    (mem_addr),
   .mem_wdata   (mem_wdata),
   .mem_rdata   (mem_rdata),
   .overflow    (overflow),
   .underflow   (underflow),
   .halted      (halted)
);

// File: tb/test_postfix_engine.sv
module test_postfix_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        instr_valid = 1'b0;
   logic        instr_ready;
   logic [15:0] instr_word = '0;
   logic        mem_rd, mem_wr;
   logic [11:0] mem_addr;
   logic [15:0] mem_wdata;
   logic [15:0] mem_rdata = '0;
   logic        overflow, underflow, halted;

   logic [15:0] mem [4096];

   int total = 0;
   int bad   = 0;
   int n_rd  = 0;
   int n_wr  = 0;
   logic [11:0] last_rd_addr = '0;

   logic [11:0] q_addr [$];
   logic [15:0] q_data [$];
   string       q_req  [$];

   always #2 clk = ~clk;

   postfix_engine i_postfix_engine (
      .clk(clk), .rst_n(rst_n),
      .instr_valid(instr_valid), .instr_ready(instr_ready), .instr_word(instr_word),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .overflow(overflow), .underflow(underflow), .halted(halted)
   );

   always @(posedge clk) begin
      if (mem_wr) mem[mem_addr] <= mem_wdata;
      if (mem_rd) mem_rdata <= mem[mem_addr];
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // monitor: compares every memory write against the scoreboard queue
   always begin
      @(negedge clk);
      #1;
      if (mem_rd) begin
         n_rd++;
         last_rd_addr = mem_addr;
      end
      if (mem_wr) begin
         n_wr++;
         if (q_addr.size() == 0) begin
            check(1'b0, "R8", "unexpected write addr", int'(mem_addr), 0);
         end else begin
            logic [11:0] ea;
            logic [15:0] ed;
            string       er;
            ea = q_addr.pop_front();
            ed = q_data.pop_front();
            er = q_req.pop_front();
            check(mem_addr == ea, er, "store address", int'(mem_addr), int'(ea));
            check(mem_wdata == ed, er, "store data", int'(mem_wdata), int'(ed));
         end
      end
   end

   task automatic send(input logic [3:0] opc, input logic [11:0] a);
      int w = 0;
      @(negedge clk);
      while (!instr_ready && w < 50) begin
         @(negedge clk);
         w++;
      end
      if (!instr_ready) check(1'b0, "R1", "ready timeout", 0, 1);
      instr_valid = 1'b1;
      instr_word  = {opc, a};
      @(negedge clk);
      instr_valid = 1'b0;
      instr_word  = '0;
   endtask

   task automatic store_expect(input logic [11:0] a, input logic [15:0] d, input string req);
      q_addr.push_back(a);
      q_data.push_back(d);
      q_req.push_back(req);
      send(4'h2, a);
   endtask

   task automatic do_reset();
      instr_valid = 1'b0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      check(1'b0, "R1", "watchdog expired", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int rd0;
      int wr0;
      for (int i = 0; i < 4096; i++) mem[i] = 16'h0;
      do_reset();

      // R12 reset state
      check(instr_ready == 1'b1, "R12", "ready after reset", int'(instr_ready), 1);
      check(overflow == 1'b0, "R12", "overflow after reset", int'(overflow), 0);
      check(underflow == 1'b0, "R12", "underflow after reset", int'(underflow), 0);
      check(halted == 1'b0, "R12", "halted after reset", int'(halted), 0);
      check(!mem_rd && !mem_wr, "R12", "strobes after reset", int'({mem_rd, mem_wr}), 0);

      // R11 postfix program, R4 add, R5 multiply
      mem[12'h010] = 16'd3; mem[12'h011] = 16'd5;
      mem[12'h012] = 16'd7; mem[12'h013] = 16'd2;
      send(4'h1, 12'h010);
      // R2 one wait cycle after a load, with read address from the field
      check(instr_ready == 1'b0, "R2", "ready in wait cycle", int'(instr_ready), 0);
      check(last_rd_addr == 12'h010, "R2", "read address", int'(last_rd_addr), 16);
      @(negedge clk);
      check(instr_ready == 1'b1, "R2", "ready after wait", int'(instr_ready), 1);
      send(4'h1, 12'h011);
      send(4'h4, 12'h000);
      send(4'h1, 12'h012);
      send(4'h1, 12'h013);
      send(4'h4, 12'h000);
      send(4'h3, 12'h000);
      store_expect(12'hABC, 16'd29, "R11");
      @(negedge clk);
      check(mem[12'hABC] == 16'd29, "R3", "memory holds stored word", int'(mem[12'hABC]), 29);

      // R5 truncated product
      mem[12'h030] = 16'h1234; mem[12'h031] = 16'h0100;
      send(4'h1, 12'h030);
      send(4'h1, 12'h031);
      send(4'h4, 12'h000);
      store_expect(12'h040, 16'h3400, "R5");

      // R4 sum wraps
      mem[12'h032] = 16'hFFFF; mem[12'h033] = 16'h0002;
      send(4'h1, 12'h032);
      send(4'h1, 12'h033);
      send(4'h3, 12'h000);
      store_expect(12'h041, 16'h0001, "R4");
      check(underflow == 1'b0 && overflow == 1'b0, "R4", "no flags after valid ops",
            int'({overflow, underflow}), 0);

      // R6 / R7 fill, overflow, then drain in reverse order
      do_reset();
      for (int i = 0; i < 9; i++) mem[12'h100 + i] = 16'h0A50 + 16'(i);
      for (int i = 0; i < 8; i++) send(4'h1, 12'(12'h100 + i));
      @(negedge clk);
      check(overflow == 1'b0, "R7", "no overflow at 8 entries", int'(overflow), 0);
      rd0 = n_rd;
      send(4'h1, 12'h108);
      check(overflow == 1'b1, "R7", "overflow on full load", int'(overflow), 1);
      check(n_rd == rd0, "R7", "no read on full load", n_rd, rd0);
      check(instr_ready == 1'b1, "R7", "no wait on rejected load", int'(instr_ready), 1);
      for (int i = 7; i >= 0; i--)
         store_expect(12'(12'h200 + i), 16'h0A50 + 16'(i), "R6");
      @(negedge clk);
      check(overflow == 1'b1, "R7", "overflow sticky", int'(overflow), 1);

      // R8 underflow on short arithmetic and empty store
      do_reset();
      mem[12'h050] = 16'hBEEF;
      send(4'h1, 12'h050);
      send(4'h3, 12'h000);
      check(underflow == 1'b1, "R8", "underflow on add with one entry", int'(underflow), 1);
      store_expect(12'h060, 16'hBEEF, "R8");
      wr0 = n_wr;
      send(4'h2, 12'h061);
      send(4'h4, 12'h000);
      @(negedge clk);
      check(n_wr == wr0, "R8", "no write on empty store", n_wr, wr0);
      check(underflow == 1'b1, "R8", "underflow sticky", int'(underflow), 1);
      check(overflow == 1'b0, "R8", "overflow untouched", int'(overflow), 0);

      // R10 unknown opcode has no effect
      do_reset();
      mem[12'h070] = 16'h1357;
      send(4'h1, 12'h070);
      rd0 = n_rd;
      wr0 = n_wr;
      send(4'h7, 12'h070);
      check(n_rd == rd0 && n_wr == wr0, "R10", "no memory access", n_rd + n_wr, rd0 + wr0);
      check(!overflow && !underflow && !halted, "R10", "flags unchanged",
            int'({overflow, underflow, halted}), 0);
      store_expect(12'h071, 16'h1357, "R10");

      // R9 stop
      send(4'h1, 12'h070);
      send(4'hF, 12'h000);
      @(negedge clk);
      check(halted == 1'b1, "R9", "halted after stop", int'(halted), 1);
      rd0 = n_rd;
      wr0 = n_wr;
      instr_valid = 1'b1;
      instr_word  = {4'h2, 12'h072};
      repeat (6) @(negedge clk);
      check(instr_ready == 1'b0, "R9", "ready stays low", int'(instr_ready), 0);
      check(n_rd == rd0 && n_wr == wr0, "R9", "no access while halted", n_rd + n_wr, rd0 + wr0);
      instr_valid = 1'b0;
      do_reset();
      check(halted == 1'b0 && instr_ready == 1'b1, "R12", "reset clears halt",
            int'({halted, instr_ready}), 1);

      check(q_addr.size() == 0, "R3", "all expected stores seen", q_addr.size(), 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule